// File: doc/BRIEF.md
# Independent Watchdog with Early-Warning Comparators

This block is a free-running watchdog. It counts in a slow time base given by a low-frequency tick enable, and it keeps counting while the core clock domain is gated for sleep or stop. A programmable prescaler thins the tick stream before it reaches an 8-bit down counter. When the counter steps below zero, the block either sends a one-cycle reset request to the reset controller or raises a sticky interrupt. Which of the two it does is chosen in a configuration register.

Two comparators each watch the down counter against their own armed threshold. Each raises an early-warning interrupt, so software can service the watchdog before it expires. Software services the watchdog by writing a 16-bit key to a refresh register. A correct key reloads the counter and restarts the prescaler. Any other value is discarded.

Software reaches the block through a simple write port and a combinational read port. There are six registers:

| Address | Register | Fields |
|---|---|---|
| 0 | CTRL | bit 0 enable, bit 1 mode, bits 27:16 divider |
| 1 | RELOAD | bits 7:0 reload value |
| 2 | THRESH | comparator i threshold at bits 8i+7:8i, arm bit at bit 16+i |
| 3 | KEY | write-only refresh key |
| 4 | FLAGS | bit 0 underflow flag, bit 1+i comparator i flag |
| 5 | COUNT | read-only counter value |

Top module: `iwd_top`

## Requirements
- R1: After reset the register values are as follows: CTRL (address 0) reads 0, RELOAD (address 1) reads 0xFF, THRESH (address 2) reads 0, FLAGS (address 4) reads 0, and COUNT (address 5) reads 0xFF. The outputs rst_req, uf_irq and early_irq are all low.
- R2: While CTRL bit 0 (enable) is 0, ticks on lf_tick leave COUNT unchanged.
- R3: The divider in CTRL[27:16] sets the decrement rate. With a divider value D, the counter decrements once every D+1 ticks of lf_tick.
- R4: Each counter step decrements COUNT by one. A step taken when COUNT is 0 is an underflow: it reloads COUNT from RELOAD[7:0].
- R5: When CTRL bit 1 (mode) is 0, an underflow drives rst_req high for exactly one clock cycle. This happens in the cycle after the underflow step.
- R6: When CTRL bit 1 is 1, an underflow sets FLAGS bit 0 and drives uf_irq high, and rst_req stays low.
- R7: Comparator i is armed by THRESH bit 16+i, and its threshold is THRESH[8i+7:8i]. When the counter is armed and decrements onto that threshold, comparator i sets FLAGS bit 1+i, and early_irq[i] follows that bit.
- R8: The FLAGS bits are sticky. Writing 1 to a FLAGS bit clears it. If a flag is set and cleared in the same cycle, the set wins.
- R9: Writing 0xA5C3 to the low 16 bits of KEY (address 3) reloads COUNT from RELOAD and restarts the prescaler. Writing any other value to KEY has no effect.
- R10: Once enable is 1, it stays 1 until reset. While the block is enabled, writes to the mode bit and to the divider field are ignored.
- R11: While core_gate is high, all register writes are ignored, including writes to KEY. Counting continues while core_gate is high.
- R12: If a valid refresh and an underflow step fall in the same cycle, the refresh wins. COUNT reloads and no underflow action follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lf_tick | input | 1 | Low-frequency time-base enable |
| core_gate | input | 1 | High while the core clock domain is gated; blocks register writes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| rst_req | output | 1 | One-cycle reset request on underflow in reset mode |
| uf_irq | output | 1 | Underflow interrupt (sticky flag) |
| early_irq | output | 2 | Early-warning interrupts, one per comparator |

## Verification
Two functions can fall in the same cycle. The first pair is a refresh key write landing on the very tick that would take the counter below zero. The bench first walks the counter to 0. It then drives the key write and lf_tick together in one cycle. It judges the result by COUNT holding the reload value and by no reset pulse being seen. The second pair is a comparator hit coinciding with a write-1-to-clear of that same flag. The bench judges this case by the flag reading back as set.

// File: rtl/iwd_pkg.sv
package iwd_pkg;

   // register addresses; software depends on this map
   typedef enum logic [2:0] {
      IWD_CTRL   = 3'd0,
      IWD_RELOAD = 3'd1,
      IWD_THRESH = 3'd2,
      IWD_KEY    = 3'd3,
      IWD_FLAGS  = 3'd4,
      IWD_COUNT  = 3'd5
   } iwd_reg_e;

   // field positions
   localparam int IWD_EN_BIT   = 0;
   localparam int IWD_MODE_BIT = 1;
   localparam int IWD_DIV_LSB  = 16;
   localparam int IWD_ARM_LSB  = 16;

endpackage

// File: rtl/iwd_prescaler.sv
module iwd_prescaler #(
   parameter int PRE_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [PRE_W-1:0] div,
   output logic             step
);

   logic [PRE_W-1:0] pre_q;
   logic             wrap;

   assign wrap = (pre_q >= div);
   assign step = run && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (clr) begin
         pre_q <= '0;
      end else if (run) begin
         if (wrap) pre_q <= '0;
         else      pre_q <= pre_q + PRE_W'(1);
      end
   end

endmodule

// File: rtl/iwd_counter.sv
module iwd_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             refresh,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt,
   output logic             dec,
   output logic             uf
);

   logic at_zero;

   assign at_zero = (cnt == '0);
   assign dec     = step && !at_zero && !refresh;
   assign uf      = step &&  at_zero && !refresh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '1;
      end else if (refresh || uf) begin
         cnt <= reload;
      end else if (dec) begin
         cnt <= cnt - CNT_W'(1);
      end
   end

endmodule

// File: rtl/iwd_early_cmp.sv
module iwd_early_cmp #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [CNT_W-1:0] thr,
   input  logic             dec,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic             clr,
   output logic             flag
);

   logic hit;

   assign hit = arm && dec && (cnt_nxt == thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= hit | (flag & ~clr);
   end

endmodule

// File: rtl/iwd_top.sv
module iwd_top
   import iwd_pkg::*;
#(
   parameter int          DATA_W  = 32,
   parameter int          CNT_W   = 8,
   parameter int          PRE_W   = 12,
   parameter int          NUM_CMP = 2,
   parameter int          KEY_W   = 16,
   parameter logic [15:0] KEY     = 16'hA5C3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lf_tick,
   input  logic               core_gate,
   input  logic               wr_en,
   input  logic [2:0]         wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [2:0]         rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   output logic               rst_req,
   output logic               uf_irq,
   output logic [NUM_CMP-1:0] early_irq
);

   localparam int NFLAG = NUM_CMP + 1;

   // elaboration-time parameter checks
   if (DATA_W < IWD_DIV_LSB + PRE_W) begin : g_bad_div
      $error("iwd_top: divider field does not fit DATA_W");
   end
   if (NUM_CMP * CNT_W > IWD_ARM_LSB) begin : g_bad_thr
      $error("iwd_top: thresholds overlap arm bits");
   end
   if (DATA_W < IWD_ARM_LSB + NUM_CMP || DATA_W < KEY_W || DATA_W < NFLAG) begin : g_bad_w
      $error("iwd_top: DATA_W too narrow");
   end
   if (NUM_CMP < 1 || KEY_W > 16 || CNT_W < 2) begin : g_bad_cfg
      $error("iwd_top: unsupported configuration");
   end

   logic                  bus_we;
   logic                  cfg_en, cfg_mode;
   logic [PRE_W-1:0]      cfg_div;
   logic [CNT_W-1:0]      cfg_reload;
   logic [CNT_W-1:0]      thr_q [NUM_CMP];
   logic [NUM_CMP-1:0]    arm_q;
   logic                  do_refresh;
   logic [NFLAG-1:0]      flag_clr;
   logic                  step, dec, uf_evt;
   logic [CNT_W-1:0]      count, cnt_nxt;
   logic                  uf_flag;
   logic [NUM_CMP-1:0]    cmp_flag;
   logic                  unused_wr;

   assign unused_wr  = ^wr_data;
   assign bus_we     = wr_en && !core_gate;
   assign do_refresh = bus_we && (wr_addr == IWD_KEY) && (wr_data[KEY_W-1:0] == KEY[KEY_W-1:0]);
   assign flag_clr   = (bus_we && wr_addr == IWD_FLAGS) ? wr_data[NFLAG-1:0] : '0;
   assign cnt_nxt    = count - CNT_W'(1);

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en     <= 1'b0;
         cfg_mode   <= 1'b0;
         cfg_div    <= '0;
         cfg_reload <= '1;
         arm_q      <= '0;
         for (int i = 0; i < NUM_CMP; i++) thr_q[i] <= '0;
      end else if (bus_we) begin
         if (wr_addr == IWD_CTRL) begin
            if (wr_data[IWD_EN_BIT]) cfg_en <= 1'b1;
            if (!cfg_en) begin
               cfg_mode <= wr_data[IWD_MODE_BIT];
               cfg_div  <= wr_data[IWD_DIV_LSB +: PRE_W];
            end
         end
         if (wr_addr == IWD_RELOAD) cfg_reload <= wr_data[CNT_W-1:0];
         if (wr_addr == IWD_THRESH) begin
            for (int i = 0; i < NUM_CMP; i++) begin
               thr_q[i] <= wr_data[i*CNT_W +: CNT_W];
               arm_q[i] <= wr_data[IWD_ARM_LSB + i];
            end
         end
      end
   end

   iwd_prescaler #(.PRE_W(PRE_W)) i_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (cfg_en && lf_tick),
      .clr   (do_refresh),
      .div   (cfg_div),
      .step  (step)
   );

   iwd_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .refresh (do_refresh),
      .reload  (cfg_reload),
      .cnt     (count),
      .dec     (dec),
      .uf      (uf_evt)
   );

   for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
      iwd_early_cmp #(.CNT_W(CNT_W)) i_cmp (
         .clk     (clk),
         .rst_n   (rst_n),
         .arm     (arm_q[g]),
         .thr     (thr_q[g]),
         .dec     (dec),
         .cnt_nxt (cnt_nxt),
         .clr     (flag_clr[g+1]),
         .flag    (cmp_flag[g])
      );
   end

   // underflow action
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req <= 1'b0;
         uf_flag <= 1'b0;
      end else begin
         rst_req <= uf_evt && !cfg_mode;
         uf_flag <= (uf_evt && cfg_mode) | (uf_flag & ~flag_clr[0]);
      end
   end

   assign uf_irq    = uf_flag;
   assign early_irq = cmp_flag;

   // read mux
   always_comb begin
      rd_data = '0;
      case (rd_addr)
         IWD_CTRL: begin
            rd_data[IWD_EN_BIT]               = cfg_en;
            rd_data[IWD_MODE_BIT]             = cfg_mode;
            rd_data[IWD_DIV_LSB +: PRE_W]     = cfg_div;
         end
         IWD_RELOAD: rd_data[CNT_W-1:0] = cfg_reload;
         IWD_THRESH: begin
            for (int i = 0; i < NUM_CMP; i++) begin
               rd_data[i*CNT_W +: CNT_W]  = thr_q[i];
               rd_data[IWD_ARM_LSB + i]   = arm_q[i];
            end
         end
         IWD_FLAGS: rd_data[NFLAG-1:0] = {cmp_flag, uf_flag};
         IWD_COUNT: rd_data[CNT_W-1:0] = count;
         default:   rd_data = '0;
      endcase
   end

endmodule

// File: rtl/iwd_top_chk.sv
module iwd_top_chk #(
   parameter int CNT_W   = 8,
   parameter int NUM_CMP = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rst_req,
   input logic               uf_irq,
   input logic               cfg_en,
   input logic               cfg_mode,
   input logic [CNT_W-1:0]   cfg_reload,
   input logic               core_gate,
   input logic               do_refresh,
   input logic [CNT_W-1:0]   count,
   input logic [NUM_CMP:0]   flag_clr
);

   // R2
   disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && !do_refresh) |=> $stable(count));

   // R6
   irq_mode_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_mode |-> !rst_req);

   // R8
   uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_irq && !flag_clr[0]) |=> uf_irq);

   // R9
   refresh_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_refresh |=> (count == $past(cfg_reload)));

   // R10
   en_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |=> cfg_en);

   // R11
   gate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_gate |=> $stable(cfg_reload));

endmodule

bind iwd_top iwd_top_chk #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rst_req    (rst_req),
   .uf_irq     (uf_irq),
   .cfg_en     (cfg_en),
   .cfg_mode   (cfg_mode),
   .cfg_reload (cfg_reload),
   .core_gate  (core_gate),
   .do_refresh (do_refresh),
   .count      (count),
   .flag_clr   (flag_clr)
);

// File: tb/test_iwd_top.sv
`timescale 1ns/1ps
module test_iwd_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lf_tick = 1'b0;
   logic        core_gate = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        rst_req, uf_irq;
   logic [1:0]  early_irq;

   int n_tests = 0;
   int n_fail  = 0;
   int rst_seen = 0;
   bit done = 0;

   localparam logic [2:0] A_CTRL = 3'd0, A_RELOAD = 3'd1, A_THRESH = 3'd2,
                          A_KEY = 3'd3, A_FLAGS = 3'd4, A_COUNT = 3'd5;

   always #2.5 clk = ~clk;

   iwd_top i_iwd_top (
      .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .core_gate(core_gate),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .rst_req(rst_req), .uf_irq(uf_irq), .early_irq(early_irq)
   );

   always @(negedge clk) if (rst_req) rst_seen++;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // one cycle: optional write plus optional tick, starting and ending at negedge
   task automatic op(input logic we, input logic [2:0] a, input logic [31:0] d, input logic tk);
      wr_en = we; wr_addr = a; wr_data = d; lf_tick = tk;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; lf_tick = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      op(1'b1, a, d, 1'b0);
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) op(1'b0, 3'd0, 32'd0, 1'b1);
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      rd_addr = a;
      #0.5;
      d = rd_data;
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      core_gate = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset_values;
      logic [31:0] v;
      do_reset();
      rd(A_CTRL, v);   check("R1 ctrl", v, 32'h0);
      rd(A_RELOAD, v); check("R1 reload", v, 32'hFF);
      rd(A_THRESH, v); check("R1 thresh", v, 32'h0);
      rd(A_FLAGS, v);  check("R1 flags", v, 32'h0);
      rd(A_COUNT, v);  check("R1 count", v, 32'hFF);
      check("R1 outputs", {29'd0, rst_req, uf_irq, |early_irq}, 32'h0);
   endtask

   task automatic t_disabled;
      logic [31:0] v;
      do_reset();
      tick(5);
      rd(A_COUNT, v); check("R2 count frozen", v, 32'hFF);
   endtask

   task automatic t_prescaler_and_key;
      logic [31:0] v;
      do_reset();
      wr(A_RELOAD, 32'd10);
      wr(A_KEY, 32'hA5C3);
      wr(A_CTRL, (32'd3 << 16) | 32'd1);
      tick(3);
      rd(A_COUNT, v); check("R3 no step before div+1", v, 32'd10);
      tick(1);
      rd(A_COUNT, v); check("R3 first step", v, 32'd9);
      tick(4);
      rd(A_COUNT, v); check("R3 second step", v, 32'd8);
      tick(2);
      wr(A_KEY, 32'h0000_1234);
      rd(A_COUNT, v); check("R9 wrong key ignored", v, 32'd8);
      wr(A_KEY, 32'hFFFF_A5C3);
      rd(A_COUNT, v); check("R9 key reloads", v, 32'd10);
      tick(3);
      rd(A_COUNT, v); check("R9 prescaler cleared", v, 32'd10);
      tick(1);
      rd(A_COUNT, v); check("R9 step after full period", v, 32'd9);
   endtask

   task automatic t_reset_mode;
      logic [31:0] v;
      int base, hi;
      do_reset();
      wr(A_RELOAD, 32'd2);
      wr(A_KEY, 32'hA5C3);
      wr(A_CTRL, 32'd1);
      base = rst_seen;
      tick(2);
      rd(A_COUNT, v); check("R4 reaches zero", v, 32'd0);
      check("R5 no early reset", rst_seen - base, 0);
      tick(1);
      rd(A_COUNT, v); check("R4 underflow reloads", v, 32'd2);
      check("R5 reset pulse seen", {31'd0, rst_req}, 32'd1);
      @(negedge clk);
      hi = rst_seen - base;
      check("R5 single cycle", hi, 1);
      check("R6 no irq in reset mode", {31'd0, uf_irq}, 32'd0);
      // R10: enable sticky, mode and divider frozen
      wr(A_CTRL, (32'd2 << 16) | 32'd2);
      rd(A_CTRL, v); check("R10 ctrl locked", v, 32'd1);
      tick(1);
      rd(A_COUNT, v); check("R10 divider unchanged", v, 32'd1);
      // R11: core gate blocks writes, counting continues
      core_gate = 1'b1;
      wr(A_RELOAD, 32'd7);
      wr(A_KEY, 32'hA5C3);
      rd(A_COUNT, v); check("R11 key ignored while gated", v, 32'd1);
      tick(1);
      rd(A_COUNT, v); check("R11 counting while gated", v, 32'd0);
      core_gate = 1'b0;
      rd(A_RELOAD, v); check("R11 reload unchanged", v, 32'd2);
      // R12: refresh collides with underflow step
      base = rst_seen;
      op(1'b1, A_KEY, 32'hA5C3, 1'b1);
      rd(A_COUNT, v); check("R12 refresh wins count", v, 32'd2);
      @(negedge clk);
      check("R12 no reset pulse", rst_seen - base, 0);
   endtask

   task automatic t_compare_irq_mode;
      logic [31:0] v;
      int base;
      do_reset();
      base = rst_seen;
      wr(A_RELOAD, 32'd6);
      wr(A_THRESH, 32'h0003_0103);
      wr(A_KEY, 32'hA5C3);
      wr(A_CTRL, 32'd3);
      tick(2);
      rd(A_FLAGS, v); check("R7 no flag above thresholds", v, 32'd0);
      op(1'b1, A_FLAGS, 32'd2, 1'b1);
      rd(A_FLAGS, v); check("R8 set beats clear", v, 32'd2);
      check("R7 early_irq[0]", {30'd0, early_irq}, 32'd1);
      wr(A_FLAGS, 32'd2);
      rd(A_FLAGS, v); check("R8 w1c clears", v, 32'd0);
      tick(2);
      rd(A_FLAGS, v); check("R7 comparator 1 hit", v, 32'd4);
      tick(2);
      rd(A_FLAGS, v); check("R6 underflow flag", v, 32'd5);
      rd(A_COUNT, v); check("R4 reload in irq mode", v, 32'd6);
      check("R6 uf_irq", {31'd0, uf_irq}, 32'd1);
      check("R6 no reset request", rst_seen - base, 0);
      tick(1);
      rd(A_FLAGS, v); check("R8 flags sticky", v, 32'd5);
      wr(A_FLAGS, 32'd5);
      rd(A_FLAGS, v); check("R8 clear both", v, 32'd0);
   endtask

   initial begin
      t_reset_values();
      t_disabled();
      t_prescaler_and_key();
      t_reset_mode();
      t_compare_irq_mode();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #500000;
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule